// File: doc/BRIEF.md
# Display Memory Clear and Reset Sequencer

This block owns the control word of an eight-character display controller together with the character memory and the flash-enable memory that feed the display driver. It runs two initialisation operations. A software clear starts when the host writes the control word with bit 7 set. A hardware reset is driven by an active-low reset pin. Each operation fills every character slot with the blank code 20h, zeroes all flash-enable bits and finishes in a fixed number of clocks. While an operation runs, `busy` is high and the host bus is locked out.

The two operations treat state differently. A clear keeps the control word bits the host wrote, drops only its own trigger bit and leaves the user-defined-character address register alone. A reset zeroes the whole control word and holds the scan timing counter at zero. Several controllers released from the same reset therefore count in step. The reset does not touch the user-defined-character address register.

Top module: `disp_ctl_init`

## Requirements
- R1: A host write to the control word (address 9) with bit 7 set starts a clear. `busy` is high for exactly the three clock cycles that follow the write edge and low after the third edge.
- R2: When a clear ends, character slots 0 to 7 all hold 20h and the flash register (address 8, bit n enables flashing of slot n) reads 00h.
- R3: When a clear ends, control word bit 7 reads 0 and bits 6..0 keep the value written with the trigger. The user-defined-character address register (address 10, low 4 bits) is unchanged.
- R4: While `rst_n` is low, `busy` is high and the control word and `scan_cnt` are zero. `busy` stays high for three rising clock edges after `rst_n` rises and is low after the third. The slots then hold 20h, flash reads 00h, the control word reads 00h and the user-defined-character address is unchanged.
- R5: `scan_cnt` holds zero during reset and increases by one on every rising clock edge after `rst_n` rises, so after k edges it reads k.
- R6: A host write that is sampled while `busy` is high is discarded at every address, including a write on the last busy cycle. A write on the first cycle after `busy` falls takes effect.
- R7: A host read that is sampled while `busy` is high does not change `host_rdata`, which keeps the value from the previous accepted read.
- R8: Address map: 0 to 7 are character slots, 8 is the flash register, 9 is the control word and 10 is the user-defined-character address. Writes to addresses 11 to 15 are ignored, and reads there return 00h.
- R9: A read sampled while `busy` is low puts the addressed value on `host_rdata` at that same clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset pin; its release starts the reset sequence |
| host_wr | input | 1 | Write strobe, sampled on the rising edge |
| host_rd | input | 1 | Read strobe, sampled on the rising edge |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| busy | output | 1 | Clear or reset sequence in progress |
| ctrl_word | output | 8 | Current control word |
| disp_chars | output | 64 | Character slots, slot n at bits 8n+7..8n |
| disp_flash | output | 8 | Flash enable per slot |
| scan_cnt | output | 12 | Refresh/flash scan timing counter |

## Verification
Host bus traffic can land in the same cycle as a running sequence. The riskiest case is a write or read sampled on the final busy cycle, when the trigger bit is dropping, compared with one sampled on the first idle cycle. The bench drives a write to slot 0 so that it arrives exactly on the last busy edge and a write to slot 1 one edge later. Only slot 1 may change. A second case pulls reset low in the middle of a clear. The control word must then drop to zero at once, and a fresh three-clock sequence must follow the release.

// File: rtl/disp_init_pkg.sv
`timescale 1ns/1ps
package disp_init_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LO   = 2'd1,
      PH_HI   = 2'd2,
      PH_DONE = 2'd3
   } init_phase_e;
endpackage

// File: rtl/init_seq_fsm.sv
`timescale 1ns/1ps
module init_seq_fsm
   import disp_init_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   output init_phase_e phase,
   output logic        busy
);
   init_phase_e phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_LO;
      end else begin
         unique case (phase_q)
            PH_IDLE: if (start) phase_q <= PH_LO;
            PH_LO:   phase_q <= PH_HI;
            PH_HI:   phase_q <= PH_DONE;
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = phase_q;
   assign busy  = (phase_q != PH_IDLE);

   assert_lo_to_hi_R1: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_LO |=> phase_q == PH_HI);
   assert_hi_to_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_HI |=> phase_q == PH_DONE);
   assert_done_to_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      phase_q == PH_DONE |=> !busy);
endmodule

// File: rtl/char_flash_store.sv
`timescale 1ns/1ps
module char_flash_store
   import disp_init_pkg::*;
#(
   parameter int          NUM_CHARS = 8,
   parameter int          CHAR_W    = 8,
   parameter logic [7:0]  BLANK     = 8'h20,
   localparam int         IDX_W     = $clog2(NUM_CHARS)
)(
   input  logic                              clk,
   input  logic                              rst_n,
   input  init_phase_e                       phase,
   input  logic                              char_we,
   input  logic [IDX_W-1:0]                  char_idx,
   input  logic [CHAR_W-1:0]                 char_wdata,
   input  logic                              flash_we,
   input  logic [NUM_CHARS-1:0]              flash_wdata,
   output logic [NUM_CHARS-1:0][CHAR_W-1:0]  chars,
   output logic [NUM_CHARS-1:0]              flash
);
   localparam logic [CHAR_W-1:0] BLANK_W = CHAR_W'(BLANK);

   for (genvar s = 0; s < NUM_CHARS; s++) begin : g_slot
      localparam init_phase_e INIT_PH = (s < NUM_CHARS/2) ? PH_LO : PH_HI;
      always_ff @(posedge clk) begin
         if (phase == INIT_PH)
            chars[s] <= BLANK_W;
         else if (char_we && (char_idx == IDX_W'(s)))
            chars[s] <= char_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (phase == PH_HI)
         flash <= '0;
      else if (flash_we)
         flash <= flash_wdata;
   end

   logic all_blank;
   always_comb begin
      all_blank = 1'b1;
      for (int s = 0; s < NUM_CHARS; s++)
         if (chars[s] != BLANK_W) all_blank = 1'b0;
   end

   assert_blank_after_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_HI |=> (all_blank && flash == '0));
endmodule

// File: rtl/scan_counter.sv
`timescale 1ns/1ps
module scan_counter #(
   parameter int CNT_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt + 1'b1;
   end

   assert_scan_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> cnt == CNT_W'($past(cnt) + 1'b1));
endmodule

// File: rtl/disp_ctl_init.sv
`timescale 1ns/1ps
module disp_ctl_init
   import disp_init_pkg::*;
#(
   parameter int          NUM_CHARS = 8,
   parameter int          CHAR_W    = 8,
   parameter int          UDC_AW    = 4,
   parameter int          CNT_W     = 12,
   parameter int          CLR_BIT   = 7,
   parameter logic [7:0]  BLANK     = 8'h20,
   localparam int         IDX_W     = $clog2(NUM_CHARS),
   localparam int         ADDR_W    = $clog2(NUM_CHARS + 3)
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        host_wr,
   input  logic                        host_rd,
   input  logic [ADDR_W-1:0]           host_addr,
   input  logic [CHAR_W-1:0]           host_wdata,
   output logic [CHAR_W-1:0]           host_rdata,
   output logic                        busy,
   output logic [CHAR_W-1:0]           ctrl_word,
   output logic [NUM_CHARS*CHAR_W-1:0] disp_chars,
   output logic [NUM_CHARS-1:0]        disp_flash,
   output logic [CNT_W-1:0]            scan_cnt
);
   if (NUM_CHARS < 2 || (NUM_CHARS % 2) != 0) begin : g_bad_chars
      $error("NUM_CHARS must be even and at least 2");
   end
   if (NUM_CHARS > CHAR_W) begin : g_bad_flash
      $error("flash register must fit in one data word");
   end
   if (CLR_BIT >= CHAR_W) begin : g_bad_clr
      $error("CLR_BIT outside the control word");
   end
   if (UDC_AW > CHAR_W) begin : g_bad_udc
      $error("UDC_AW wider than the data word");
   end

   localparam logic [ADDR_W-1:0] A_FLASH = ADDR_W'(NUM_CHARS);
   localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(NUM_CHARS + 1);
   localparam logic [ADDR_W-1:0] A_UDC   = ADDR_W'(NUM_CHARS + 2);
   localparam logic [CHAR_W-1:0] KEEP_M  = ~(CHAR_W'(1) << CLR_BIT);

   init_phase_e phase;
   logic        wr_ok, start;
   logic [CHAR_W-1:0] ctrl_q;
   logic [UDC_AW-1:0] udc_addr_q;
   logic [NUM_CHARS-1:0][CHAR_W-1:0] chars;
   logic [NUM_CHARS-1:0] flash;
   logic [CHAR_W-1:0] rd_mux;

   assign wr_ok = host_wr && !busy;
   assign start = wr_ok && (host_addr == A_CTRL) && host_wdata[CLR_BIT];

   init_seq_fsm u_seq (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .phase (phase),
      .busy  (busy)
   );

   char_flash_store #(
      .NUM_CHARS (NUM_CHARS),
      .CHAR_W    (CHAR_W),
      .BLANK     (BLANK)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (phase),
      .char_we     (wr_ok && (host_addr < A_FLASH)),
      .char_idx    (host_addr[IDX_W-1:0]),
      .char_wdata  (host_wdata),
      .flash_we    (wr_ok && (host_addr == A_FLASH)),
      .flash_wdata (host_wdata[NUM_CHARS-1:0]),
      .chars       (chars),
      .flash       (flash)
   );

   scan_counter #(.CNT_W(CNT_W)) u_scan (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt   (scan_cnt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= '0;
      else if (wr_ok && host_addr == A_CTRL)
         ctrl_q <= host_wdata;
      else if (phase == PH_DONE)
         ctrl_q[CLR_BIT] <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (wr_ok && host_addr == A_UDC)
         udc_addr_q <= host_wdata[UDC_AW-1:0];
   end

   always_comb begin
      if (host_addr < A_FLASH)       rd_mux = chars[host_addr[IDX_W-1:0]];
      else if (host_addr == A_FLASH) rd_mux = CHAR_W'(flash);
      else if (host_addr == A_CTRL)  rd_mux = ctrl_q;
      else if (host_addr == A_UDC)   rd_mux = CHAR_W'(udc_addr_q);
      else                           rd_mux = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   host_rdata <= '0;
      else if (host_rd && !busy)    host_rdata <= rd_mux;
   end

   assign ctrl_word  = ctrl_q;
   assign disp_chars = chars;
   assign disp_flash = flash;

   assert_trigger_dropped_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !ctrl_q[CLR_BIT]);
   assert_ctrl_kept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (ctrl_q & KEEP_M) == ($past(ctrl_q) & KEEP_M));
   assert_udc_kept_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(udc_addr_q));
   assert_rdata_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(host_rdata));
endmodule

// File: tb/disp_ctl_init_tb.sv
`timescale 1ns/1ps
module disp_ctl_init_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic        host_rd = 1'b0;
   logic [3:0]  host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        busy;
   logic [7:0]  ctrl_word;
   logic [63:0] disp_chars;
   logic [7:0]  disp_flash;
   logic [11:0] scan_cnt;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   disp_ctl_init dut_i (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .busy(busy), .ctrl_word(ctrl_word), .disp_chars(disp_chars),
      .disp_flash(disp_flash), .scan_cnt(scan_cnt)
   );

   always #2 clk = ~clk;

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_write(logic [3:0] a, logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic do_read(logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic check_blank(string req);
      logic [7:0] d;
      for (int i = 0; i < 8; i++) begin
         do_read(4'(i), d);
         check(req, $sformatf("slot %0d", i), d, 8'h20);
      end
      do_read(4'd8, d);
      check(req, "flash", d, 8'h00);
   endtask

   task automatic release_and_count(string req);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 1; k <= 3; k++) begin
         @(negedge clk);
         check("R5", $sformatf("scan_cnt after %0d edges", k), scan_cnt, k);
         check(req, $sformatf("busy after %0d edges", k), busy, (k < 3) ? 1 : 0);
      end
   endtask

   task automatic t_power_reset();
      logic [7:0] d;
      repeat (2) @(negedge clk);
      check("R4", "busy in reset", busy, 1);
      check("R4", "ctrl in reset", ctrl_word, 0);
      check("R5", "scan_cnt in reset", scan_cnt, 0);
      release_and_count("R4");
      check_blank("R4");
      do_read(4'd9, d);
      check("R4", "ctrl after reset", d, 8'h00);
   endtask

   task automatic t_map_and_clear();
      logic [7:0] d;
      for (int i = 0; i < 8; i++) do_write(4'(i), 8'h41 + 8'(i));
      do_write(4'd8, 8'hA5);
      do_write(4'd10, 8'h09);
      do_write(4'd9, 8'h45);
      do_write(4'd12, 8'hFF);
      do_read(4'd3, d);   check("R9", "slot 3 readback", d, 8'h44);
      do_read(4'd8, d);   check("R8", "flash readback", d, 8'hA5);
      do_read(4'd9, d);   check("R8", "ctrl readback", d, 8'h45);
      do_read(4'd10, d);  check("R8", "udc readback", d, 8'h09);
      do_read(4'd12, d);  check("R8", "unused address", d, 8'h00);
      check("R8", "slot 7 on display port", disp_chars[63:56], 8'h48);
      do_write(4'd9, 8'h83);
      check("R1", "busy after trigger edge", busy, 1);
      @(negedge clk); check("R1", "busy 2nd cycle", busy, 1);
      @(negedge clk); check("R1", "busy 3rd cycle", busy, 1);
      @(negedge clk); check("R1", "busy after 3 cycles", busy, 0);
      check_blank("R2");
      do_read(4'd9, d);   check("R3", "ctrl after clear", d, 8'h03);
      do_read(4'd10, d);  check("R3", "udc after clear", d, 8'h09);
   endtask

   task automatic t_busy_discard();
      logic [7:0] d;
      do_read(4'd10, d);
      check("R9", "udc read before clear", d, 8'h09);
      do_write(4'd9, 8'h81);
      host_wr = 1'b1; host_addr = 4'd2; host_wdata = 8'h5A;
      host_rd = 1'b1;
      @(negedge clk);
      host_addr = 4'd10; host_wdata = 8'h03;
      check("R7", "rdata during busy", host_rdata, 8'h09);
      @(negedge clk);
      host_addr = 4'd9; host_wdata = 8'h7F;
      check("R7", "rdata during busy", host_rdata, 8'h09);
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      check("R7", "rdata after busy", host_rdata, 8'h09);
      do_read(4'd2, d);   check("R6", "slot 2 write while busy", d, 8'h20);
      do_read(4'd10, d);  check("R6", "udc write while busy", d, 8'h09);
      do_read(4'd9, d);   check("R6", "ctrl write while busy", d, 8'h01);
   endtask

   task automatic t_last_cycle_edge();
      logic [7:0] d;
      do_write(4'd9, 8'h82);
      @(negedge clk);
      @(negedge clk);
      host_wr = 1'b1; host_addr = 4'd0; host_wdata = 8'h51;
      @(negedge clk);
      host_addr = 4'd1; host_wdata = 8'h52;
      @(negedge clk);
      host_wr = 1'b0;
      do_read(4'd0, d);  check("R6", "write on last busy cycle", d, 8'h20);
      do_read(4'd1, d);  check("R6", "write on first idle cycle", d, 8'h52);
      do_read(4'd9, d);  check("R3", "ctrl after clear", d, 8'h02);
   endtask

   task automatic t_reset_mid_clear();
      logic [7:0] d;
      do_write(4'd9, 8'h8C);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R4", "ctrl zero once reset asserted", ctrl_word, 0);
      check("R4", "scan_cnt zero once reset asserted", scan_cnt, 0);
      @(negedge clk);
      release_and_count("R4");
      check_blank("R4");
      do_read(4'd9, d);   check("R4", "ctrl after reset", d, 8'h00);
      do_read(4'd10, d);  check("R4", "udc kept across reset", d, 8'h09);
   endtask

   initial begin
      t_power_reset();
      t_map_and_clear();
      t_busy_discard();
      t_last_cycle_edge();
      t_reset_mid_clear();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule